// File: doc/BRIEF.md
# Seconds Counter with Self-Rearming Alarms

The block keeps time for a chip as a 32-bit count of seconds plus a sub-second count. The sub-second count advances once per `tick` pulse and wraps after a parameterized number of ticks (default 32768). Each wrap adds one to the seconds count. Software reaches the block through a simple synchronous register bus. A write is taken on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. Software can load the seconds count at any time. A write to either capture register latches both live counts at once.

Two alarm channels watch the seconds count. A channel checks for a match only in a cycle where the seconds count has just changed. When it matches, it sets its flag and adds its step value to its compare value, so it fires again later without software help. Each channel has a small state machine with two states:

- `CH_ARMED`: the channel is watching for a match.
- `CH_SPENT`: the channel does not match.

The transitions are:

- **ARMED to SPENT** (`expire`): a match happens while the step value is zero.
- **SPENT to ARMED** (`rearm`): software writes the compare register.

Each interrupt output is the channel's flag gated by its enable bit.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset every register reads zero and both `alarm_irq` bits are low.
- R2: Each `tick` advances the sub-second count (offset 0x04) by one. A tick with the count at SUB_WRAP-1 sets it to zero and adds one to the seconds count (offset 0x00).
- R3: A write to offset 0x00 loads the seconds count and clears the sub-second count. It takes priority over a `tick` in the same cycle.
- R4: A write to offset 0x04 has no effect. The sub-second count is read-only.
- R5: A write to offset 0x08 or 0x0C copies the current seconds count into 0x08 and the current sub-second count into 0x0C, both on the same edge. The written data is ignored.
- R6: A channel in `CH_ARMED` matches when its compare value equals the seconds count in the cycle after that count changed. The change can come from a tick wrap or a software write. One edge later, its flag is set and its compare value has become compare plus step. Channel 0 uses compare 0x10 and step 0x14. Channel 1 uses compare 0x18 and step 0x1C.
- R7: Writing a compare value equal to an unchanging seconds count does not set the flag.
- R8: A match with step zero moves the channel to `CH_SPENT`. In that state it does not match again, even when the seconds count is rewritten to the same value, until its compare register is written.
- R9: The flag register is at offset 0x20, with bit 0 for channel 0 and bit 1 for channel 1. Writing 1 to a bit clears that flag. A match and a clear on the same edge leave the flag set.
- R10: The enable register is at offset 0x24, with bit 0 for channel 0 and bit 1 for channel 1. Only bits [1:0] are kept. `alarm_irq[n]` is flag n AND enable n. Flags still record matches while the channel is disabled.
- R11: The seconds, compare, step and enable registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle sub-second timebase pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| alarm_irq | output | 2 | Per-channel interrupt, flag AND enable |

## Verification
The hardest case to reach is a match and a software flag clear landing on the same edge. The bench reaches it by writing the seconds register to the compare value and issuing the flag clear in the very next cycle, which is exactly when the match is evaluated.

The one-shot case needs a second change of the seconds count onto the same value. Software rewrites the seconds register to that value, and the channel must stay silent. A compare write then re-arms it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DW  = 32;
    localparam int AW  = 6;
    localparam int NCH = 2;

    localparam logic [AW-1:0] REG_SECS   = 6'h00;
    localparam logic [AW-1:0] REG_FRAC   = 6'h04;
    localparam logic [AW-1:0] REG_CAP_S  = 6'h08;
    localparam logic [AW-1:0] REG_CAP_F  = 6'h0C;
    localparam logic [AW-1:0] REG_FLAG   = 6'h20;
    localparam logic [AW-1:0] REG_ENA    = 6'h24;

    // channel n: compare at 0x10 + 8n, step at 0x14 + 8n
    function automatic logic [AW-1:0] cmp_off(input int ch);
        return AW'(16 + 8 * ch);
    endfunction

    function automatic logic [AW-1:0] step_off(input int ch);
        return AW'(20 + 8 * ch);
    endfunction

    typedef enum logic {
        CH_ARMED = 1'b0,
        CH_SPENT = 1'b1
    } ch_state_e;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int DW       = 32,
    parameter int SUB_WRAP = 32768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          sec_wr,
    input  logic [DW-1:0] sec_wdata,
    output logic [DW-1:0] sec_q,
    output logic [DW-1:0] sub_q,
    output logic          sec_new
);
    localparam logic [DW-1:0] LAST = DW'(SUB_WRAP - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q   <= '0;
            sub_q   <= '0;
            sec_new <= 1'b0;
        end else begin
            sec_new <= 1'b0;
            if (sec_wr) begin
                sec_q   <= sec_wdata;
                sub_q   <= '0;
                sec_new <= 1'b1;
            end else if (tick) begin
                if (sub_q == LAST) begin
                    sub_q   <= '0;
                    sec_q   <= sec_q + 1'b1;
                    sec_new <= 1'b1;
                end else begin
                    sub_q <= sub_q + 1'b1;
                end
            end
        end
    end

    // R2
    frac_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sec_wr && sub_q == LAST) |=> (sub_q == '0 && sec_q == $past(sec_q) + 1'b1));

    // R3
    secs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> (sec_q == $past(sec_wdata) && sub_q == '0 && sec_new));
endmodule

// File: rtl/rtc_snap.sv
module rtc_snap #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_wr,
    input  logic [DW-1:0] sec_q,
    input  logic [DW-1:0] sub_q,
    output logic [DW-1:0] cap_sec,
    output logic [DW-1:0] cap_sub
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_sec <= '0;
            cap_sub <= '0;
        end else if (cap_wr) begin
            cap_sec <= sec_q;
            cap_sub <= sub_q;
        end
    end

    // R5
    snap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr |=> (cap_sec == $past(sec_q) && cap_sub == $past(sub_q)));
endmodule

// File: rtl/rtc_alarm_chan.sv
module rtc_alarm_chan
    import rtc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] sec_q,
    input  logic          sec_new,
    input  logic          cmp_wr,
    input  logic          step_wr,
    input  logic [DW-1:0] wdata,
    input  logic          flag_clr,
    input  logic          en,
    output logic [DW-1:0] cmp_q,
    output logic [DW-1:0] step_q,
    output logic          flag_q,
    output logic          irq
);
    ch_state_e state_q, state_d;
    logic      hit;

    assign hit = (state_q == CH_ARMED) && sec_new && (cmp_q == sec_q);

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ARMED: if (hit && step_q == '0 && !cmp_wr) state_d = CH_SPENT; // expire
            CH_SPENT: if (cmp_wr) state_d = CH_ARMED;                         // rearm
            default:  state_d = CH_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_d;
    end

    // compare, step, flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            step_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (cmp_wr)   cmp_q <= wdata;
            else if (hit) cmp_q <= cmp_q + step_q;
            if (step_wr)  step_q <= wdata;
            flag_q <= hit | (flag_q & ~flag_clr);
        end
    end

    // outputs
    always_comb begin
        irq = flag_q & en;
    end

    // R6
    cmp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmp_wr) |=> (flag_q && cmp_q == $past(cmp_q) + $past(step_q)));

    // R9
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && flag_clr) |=> flag_q);

    // R8
    spent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SPENT && !cmp_wr) |=> ($stable(cmp_q) && state_q == CH_SPENT));
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
    import rtc_pkg::*;
#(
    parameter int SUB_WRAP = 32768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NCH-1:0] alarm_irq
);
    logic [DW-1:0]  sec_q, sub_q, cap_sec, cap_sub;
    logic           sec_new;
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] flag_vec;
    logic [DW-1:0]  cmp_arr  [NCH];
    logic [DW-1:0]  step_arr [NCH];

    logic sec_wr, cap_wr, ena_wr;
    assign sec_wr = bus_wr && (bus_addr == REG_SECS);
    assign cap_wr = bus_wr && ((bus_addr == REG_CAP_S) || (bus_addr == REG_CAP_F));
    assign ena_wr = bus_wr && (bus_addr == REG_ENA);

    rtc_timebase #(.DW(DW), .SUB_WRAP(SUB_WRAP)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .sec_wr(sec_wr), .sec_wdata(bus_wdata),
        .sec_q(sec_q), .sub_q(sub_q), .sec_new(sec_new)
    );

    rtc_snap #(.DW(DW)) u_snap (
        .clk(clk), .rst_n(rst_n), .cap_wr(cap_wr),
        .sec_q(sec_q), .sub_q(sub_q),
        .cap_sec(cap_sec), .cap_sub(cap_sub)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (ena_wr) en_q <= bus_wdata[NCH-1:0];
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        logic cmp_wr, step_wr, clr;
        assign cmp_wr  = bus_wr && (bus_addr == cmp_off(gi));
        assign step_wr = bus_wr && (bus_addr == step_off(gi));
        assign clr     = bus_wr && (bus_addr == REG_FLAG) && bus_wdata[gi];

        rtc_alarm_chan #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .sec_q(sec_q), .sec_new(sec_new),
            .cmp_wr(cmp_wr), .step_wr(step_wr), .wdata(bus_wdata),
            .flag_clr(clr), .en(en_q[gi]),
            .cmp_q(cmp_arr[gi]), .step_q(step_arr[gi]),
            .flag_q(flag_vec[gi]), .irq(alarm_irq[gi])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_SECS:  bus_rdata = sec_q;
            REG_FRAC:  bus_rdata = sub_q;
            REG_CAP_S: bus_rdata = cap_sec;
            REG_CAP_F: bus_rdata = cap_sub;
            REG_FLAG:  bus_rdata = DW'(flag_vec);
            REG_ENA:   bus_rdata = DW'(en_q);
            default:   bus_rdata = '0;
        endcase
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == cmp_off(c))  bus_rdata = cmp_arr[c];
            if (bus_addr == step_off(c)) bus_rdata = step_arr[c];
        end
    end

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ena_wr |=> (alarm_irq == ($past(bus_wdata[NCH-1:0]) & flag_vec)));
endmodule

// File: tb/rtc_alarm_core_tb.sv
module rtc_alarm_core_tb;
    localparam int WRAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  alarm_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_alarm_core #(.SUB_WRAP(WRAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{1'b1, 6'h00, 32'h1234_5678, 32'h0, 4'd0},
        '{1'b0, 6'h00, 32'h0, 32'h1234_5678, 4'd11},  // R11
        '{1'b0, 6'h04, 32'h0, 32'h0, 4'd3},           // R3
        '{1'b1, 6'h04, 32'h0000_FFFF, 32'h0, 4'd0},
        '{1'b0, 6'h04, 32'h0, 32'h0, 4'd4},           // R4
        '{1'b1, 6'h10, 32'hA5A5_0001, 32'h0, 4'd0},
        '{1'b0, 6'h10, 32'h0, 32'hA5A5_0001, 4'd11},  // R11
        '{1'b1, 6'h1C, 32'h3, 32'h0, 4'd0},
        '{1'b0, 6'h1C, 32'h0, 32'h3, 4'd11},          // R11
        '{1'b1, 6'h24, 32'hFFFF_FFFF, 32'h0, 4'd0},
        '{1'b0, 6'h24, 32'h0, 32'h3, 4'd10},          // R10
        '{1'b0, 6'h20, 32'h0, 32'h0, 4'd7}            // R7
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 10; a++) rd_chk("R1", 6'(4 * a), 32'h0);
        check("R1 irq", 32'(alarm_irq), 32'h0);

        // table walk
        for (int i = 0; i < 12; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else rd_chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
        end

        // R2 tick advance and wrap
        wr(6'h00, 32'd100);
        ticks(3);
        rd_chk("R2 frac", 6'h04, 32'd3);
        rd_chk("R2 secs", 6'h00, 32'd100);
        ticks(1);
        rd_chk("R2 wrap frac", 6'h04, 32'd0);
        rd_chk("R2 wrap secs", 6'h00, 32'd101);

        // R3 write beats tick in the same cycle
        ticks(2);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 6'h00; bus_wdata = 32'd500;
        @(posedge clk); #1;
        tick = 1'b0; bus_wr = 1'b0;
        rd_chk("R3 secs", 6'h00, 32'd500);
        rd_chk("R3 frac", 6'h04, 32'd0);

        // R5 snapshot
        wr(6'h00, 32'd700);
        ticks(2);
        wr(6'h08, 32'hDEAD_BEEF);
        rd_chk("R5 cap secs", 6'h08, 32'd700);
        rd_chk("R5 cap frac", 6'h0C, 32'd2);
        ticks(1);
        wr(6'h0C, 32'h0);
        rd_chk("R5 cap secs b", 6'h08, 32'd700);
        rd_chk("R5 cap frac b", 6'h0C, 32'd3);

        // R6 periodic match on tick wrap
        wr(6'h24, 32'h1);
        wr(6'h10, 32'd1000);
        wr(6'h14, 32'd5);
        wr(6'h00, 32'd999);
        ticks(WRAP);
        idle(1);
        rd_chk("R6 flag", 6'h20, 32'h1);
        rd_chk("R6 cmp", 6'h10, 32'd1005);
        check("R6 irq", 32'(alarm_irq), 32'h1);
        wr(6'h20, 32'h1);
        rd_chk("R9 clear", 6'h20, 32'h0);
        check("R9 irq", 32'(alarm_irq), 32'h0);
        wr(6'h00, 32'd1004);
        ticks(WRAP);
        idle(1);
        rd_chk("R6 refire flag", 6'h20, 32'h1);
        rd_chk("R6 refire cmp", 6'h10, 32'd1010);
        wr(6'h20, 32'h1);

        // R9 match and clear on the same edge
        wr(6'h00, 32'd1010);
        wr(6'h20, 32'h1);
        rd_chk("R9 set wins", 6'h20, 32'h1);
        rd_chk("R9 cmp", 6'h10, 32'd1015);
        wr(6'h20, 32'h1);

        // R7 stale equality
        wr(6'h10, 32'd1010);
        idle(3);
        rd_chk("R7 flag", 6'h20, 32'h0);
        rd_chk("R7 cmp", 6'h10, 32'd1010);

        // R8 one-shot
        wr(6'h24, 32'h3);
        wr(6'h1C, 32'h0);
        wr(6'h18, 32'd2000);
        wr(6'h00, 32'd2000);
        idle(1);
        rd_chk("R8 first", 6'h20, 32'h2);
        check("R8 irq", 32'(alarm_irq), 32'h2);
        wr(6'h20, 32'h2);
        wr(6'h00, 32'd2000);
        idle(1);
        rd_chk("R8 spent", 6'h20, 32'h0);
        rd_chk("R8 cmp", 6'h18, 32'd2000);
        wr(6'h18, 32'd2000);
        wr(6'h00, 32'd2000);
        idle(1);
        rd_chk("R8 rearm", 6'h20, 32'h2);
        wr(6'h20, 32'h3);

        // R10 disabled channel still records
        wr(6'h24, 32'h0);
        wr(6'h10, 32'd3000);
        wr(6'h14, 32'd1);
        wr(6'h00, 32'd3000);
        idle(1);
        rd_chk("R10 flag", 6'h20, 32'h1);
        check("R10 irq off", 32'(alarm_irq), 32'h0);
        wr(6'h24, 32'h1);
        check("R10 irq on", 32'(alarm_irq), 32'h1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule